// File: doc/BRIEF.md
# Latched Prioritized Event Controller

This block gathers level-sensitive interrupt requests from up to 64 peripheral sources. It steers each source to one of seven general-purpose priority levels, numbered 7 through 13. The steering comes from a bank of eight 32-bit assignment registers. Each register holds eight 4-bit fields, and the bank comes out of reset with a fixed default map.

Requests are recorded per level in a 16-bit pending register, one bit per event class, and gated by a 16-bit enable register. The block continuously offers the core the most urgent level that is both pending and enabled. When the core returns an acknowledge strobe naming a level, that level's pending bit is cleared.

A small register port gives software read and write access. Every access is qualified by a privilege input. Without privilege, writes are dropped and reads return zero. With privilege, software may cancel pending events, but only for levels whose enable bit is clear.

Top module: `prio_event_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, the pending and enable registers read 0 and `req_valid` is 0.
- R2: After reset the assignment fields hold a fixed default map, where a field value of v routes to level v+7:
  - sources 8-19 have value 1;
  - sources 20-31 have value 2;
  - sources 32-43 have value 3;
  - sources 44-49 have value 4;
  - sources 50-51 have value 5;
  - source 52 has value 6;
  - sources 0-7 and 53-63 have value 0.
- R3: Source s is governed by the 4-bit field at bits [4*(s%8)+3 : 4*(s%8)] of assignment register s/8 (addresses 0-7). Field value v in 0..6 routes the source to level v+7, and values 7..15 route it nowhere.
- R4: A source that is high at a rising edge sets the pending bit of its level, visible after that edge. The bit stays set after the source drops.
- R5: The enable register sits at address 9, bits [15:0]. Only levels whose enable bit is 1 can be offered on the request output.
- R6: `req_valid` is 1 exactly when some level is both pending and enabled, and `req_level` is then the lowest-numbered such level.
- R7: An acknowledge (`ack_valid` with `ack_level`) clears that level's pending bit at the same edge. A new source assertion for that level in the same cycle wins, and the bit stays set.
- R8: The pending register sits at address 8, bits [15:0]. A privileged write of 1 to a bit cancels that pending event only if its enable bit is clear. A 1 on a bit whose enable bit is set, or any 0, leaves the bit unchanged.
- R9: Writes with `reg_super` low change no register.
- R10: `reg_rdata` is combinational. It is 0 unless `reg_rd` and `reg_super` are both high. Privileged reads return the addressed register, and addresses 10-15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_irq | input | 64 | Level-sensitive peripheral requests |
| ack_valid | input | 1 | Core accepts an event this cycle |
| ack_level | input | 4 | Level being accepted |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_super | input | 1 | Privileged access qualifier |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data |
| req_valid | output | 1 | A pending, enabled level exists |
| req_level | output | 4 | Most urgent pending, enabled level |

## Verification
The assertions take for granted that every input is synchronous to the clock and free of unknowns once reset is released. They also assume an acknowledge may name any level, including one that is not pending, and that a write and a read may land in the same cycle.

The stimulus keeps to this by driving all inputs on the falling edge. It holds them stable across the rising edge. Its random phase issues acknowledges both for the offered level and for arbitrary levels, and mixes privileged and unprivileged accesses to every address.

// File: rtl/evt_pkg.sv
package evt_pkg;

    localparam int NUM_LVL     = 16;
    localparam int LVL_W       = 4;
    localparam int FLD_W       = 4;
    localparam int DW          = 32;
    localparam int AW          = 4;
    localparam int GP_BASE     = 7;
    localparam int GP_CNT      = 7;
    localparam int PER_REG     = DW / FLD_W;
    localparam int DEF_SRC     = 64;

    typedef logic [NUM_LVL-1:0] lvl_vec_t;

    typedef struct packed {
        logic             valid;
        logic [LVL_W-1:0] level;
    } lvl_req_t;

    typedef enum logic [1:0] {
        SEL_ASSIGN = 2'd0,
        SEL_LATCH  = 2'd1,
        SEL_MASK   = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    // Reset value of a source's routing field.
    function automatic logic [FLD_W-1:0] default_field(input int s);
        if (s < 8)       return FLD_W'(0);
        else if (s < 20) return FLD_W'(1);
        else if (s < 32) return FLD_W'(2);
        else if (s < 44) return FLD_W'(3);
        else if (s < 50) return FLD_W'(4);
        else if (s < 52) return FLD_W'(5);
        else if (s == 52) return FLD_W'(6);
        else             return FLD_W'(0);
    endfunction

    // Register address decode; assignment words occupy the low addresses.
    function automatic reg_sel_e decode_addr(input logic [AW-1:0] a, input int n_areg);
        if (int'(a) < n_areg)        return SEL_ASSIGN;
        else if (int'(a) == n_areg)  return SEL_LATCH;
        else if (int'(a) == n_areg + 1) return SEL_MASK;
        else                         return SEL_NONE;
    endfunction

endpackage

// File: rtl/evt_assign_file.sv
module evt_assign_file
    import evt_pkg::*;
#(
    parameter int NUM_SRC = DEF_SRC
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr_en,
    input  logic [AW-1:0]                   wr_addr,
    input  logic [DW-1:0]                   wr_data,
    input  logic [AW-1:0]                   rd_addr,
    output logic [DW-1:0]                   rd_word,
    output logic [NUM_SRC-1:0][FLD_W-1:0]   fields
);
    localparam int NUM_AREG = NUM_SRC / PER_REG;

    for (genvar r = 0; r < NUM_AREG; r++) begin : g_reg
        for (genvar f = 0; f < PER_REG; f++) begin : g_fld
            localparam int IDX = r * PER_REG + f;
            always_ff @(posedge clk) begin
                if (rst)
                    fields[IDX] <= default_field(IDX);
                else if (wr_en && (wr_addr == AW'(r)))
                    fields[IDX] <= wr_data[f*FLD_W +: FLD_W];
            end
        end
    end

    always_comb begin
        rd_word = '0;
        for (int r = 0; r < NUM_AREG; r++) begin
            if (rd_addr == AW'(r)) begin
                for (int f = 0; f < PER_REG; f++)
                    rd_word[f*FLD_W +: FLD_W] = fields[r*PER_REG + f];
            end
        end
    end

endmodule

// File: rtl/evt_src_router.sv
module evt_src_router
    import evt_pkg::*;
#(
    parameter int NUM_SRC = DEF_SRC
) (
    input  logic [NUM_SRC-1:0]              src,
    input  logic [NUM_SRC-1:0][FLD_W-1:0]   fields,
    output lvl_vec_t                        set_vec
);
    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
        if (l >= GP_BASE && l < GP_BASE + GP_CNT) begin : g_gp
            logic [NUM_SRC-1:0] hit;
            always_comb begin
                for (int s = 0; s < NUM_SRC; s++)
                    hit[s] = src[s] && (fields[s] == FLD_W'(l - GP_BASE));
            end
            assign set_vec[l] = |hit;
        end else begin : g_none
            assign set_vec[l] = 1'b0;
        end
    end

endmodule

// File: rtl/evt_pend_latch.sv
module evt_pend_latch
    import evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  lvl_vec_t         set_vec,
    input  logic             ack_valid,
    input  logic [LVL_W-1:0] ack_level,
    input  logic             cancel_en,
    input  lvl_vec_t         cancel_bits,
    input  logic             mask_wr_en,
    input  lvl_vec_t         mask_wdata,
    output lvl_vec_t         latch_q,
    output lvl_vec_t         mask_q
);
    lvl_vec_t ack_oh;
    lvl_vec_t cancel_eff;
    lvl_vec_t clr_vec;

    always_comb begin
        ack_oh     = ack_valid ? (lvl_vec_t'(1) << ack_level) : '0;
        // Software may only cancel events that are currently disabled.
        cancel_eff = cancel_en ? (cancel_bits & ~mask_q) : '0;
        clr_vec    = ack_oh | cancel_eff;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
            mask_q  <= '0;
        end else begin
            latch_q <= (latch_q & ~clr_vec) | set_vec;
            if (mask_wr_en)
                mask_q <= mask_wdata;
        end
    end

endmodule

// File: rtl/evt_prio_pick.sv
module evt_prio_pick
    import evt_pkg::*;
(
    input  lvl_vec_t latch_q,
    input  lvl_vec_t mask_q,
    output lvl_req_t pick
);
    lvl_vec_t live;

    always_comb begin
        live = latch_q & mask_q;
        pick = '0;
        for (int i = NUM_LVL - 1; i >= 0; i--) begin
            if (live[i]) begin
                pick.valid = 1'b1;
                pick.level = LVL_W'(i);
            end
        end
    end

endmodule

// File: rtl/prio_event_ctrl.sv
module prio_event_ctrl
    import evt_pkg::*;
#(
    parameter int NUM_SRC = DEF_SRC
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_irq,
    input  logic               ack_valid,
    input  logic [LVL_W-1:0]   ack_level,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic               reg_super,
    input  logic [AW-1:0]      reg_addr,
    input  logic [DW-1:0]      reg_wdata,
    output logic [DW-1:0]      reg_rdata,
    output logic               req_valid,
    output logic [LVL_W-1:0]   req_level
);
    localparam int NUM_AREG = NUM_SRC / PER_REG;

    logic [NUM_SRC-1:0][FLD_W-1:0] fields;
    logic [DW-1:0]                 assign_word;
    lvl_vec_t                      set_vec;
    lvl_vec_t                      latch_q;
    lvl_vec_t                      mask_q;
    lvl_req_t                      pick;
    reg_sel_e                      sel;
    logic                          wr_ok;

    always_comb begin
        sel   = decode_addr(reg_addr, NUM_AREG);
        wr_ok = reg_wr && reg_super;
    end

    evt_assign_file #(.NUM_SRC(NUM_SRC)) u_assign (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_ok && (sel == SEL_ASSIGN)),
        .wr_addr (reg_addr),
        .wr_data (reg_wdata),
        .rd_addr (reg_addr),
        .rd_word (assign_word),
        .fields  (fields)
    );

    evt_src_router #(.NUM_SRC(NUM_SRC)) u_router (
        .src     (src_irq),
        .fields  (fields),
        .set_vec (set_vec)
    );

    evt_pend_latch u_latch (
        .clk         (clk),
        .rst         (rst),
        .set_vec     (set_vec),
        .ack_valid   (ack_valid),
        .ack_level   (ack_level),
        .cancel_en   (wr_ok && (sel == SEL_LATCH)),
        .cancel_bits (reg_wdata[NUM_LVL-1:0]),
        .mask_wr_en  (wr_ok && (sel == SEL_MASK)),
        .mask_wdata  (reg_wdata[NUM_LVL-1:0]),
        .latch_q     (latch_q),
        .mask_q      (mask_q)
    );

    evt_prio_pick u_pick (
        .latch_q (latch_q),
        .mask_q  (mask_q),
        .pick    (pick)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_rd && reg_super) begin
            unique case (sel)
                SEL_ASSIGN: reg_rdata = assign_word;
                SEL_LATCH:  reg_rdata = DW'(latch_q);
                SEL_MASK:   reg_rdata = DW'(mask_q);
                default:    reg_rdata = '0;
            endcase
        end
        req_valid = pick.valid;
        req_level = pick.level;
    end

endmodule

// File: rtl/prio_event_ctrl_chk.sv
module prio_event_ctrl_chk
    import evt_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             reg_wr,
    input logic             reg_rd,
    input logic             reg_super,
    input logic [AW-1:0]    reg_addr,
    input logic [DW-1:0]    reg_wdata,
    input logic [DW-1:0]    reg_rdata,
    input logic             ack_valid,
    input logic [LVL_W-1:0] ack_level,
    input lvl_vec_t         set_vec,
    input lvl_vec_t         latch_q,
    input lvl_vec_t         mask_q,
    input logic             req_valid,
    input logic [LVL_W-1:0] req_level
);
    assert_req_enabled_R5: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (latch_q[req_level] && mask_q[req_level]));

    assert_mask_write_R5: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_super && reg_addr == AW'(9)) |=> (mask_q == $past(reg_wdata[NUM_LVL-1:0])));

    assert_lowest_wins_R6: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> ((latch_q & mask_q & ((lvl_vec_t'(1) << req_level) - lvl_vec_t'(1))) == '0));

    assert_idle_when_empty_R6: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> ((latch_q & mask_q) == '0));

    assert_set_sticks_R4: assert property (@(posedge clk) disable iff (rst)
        (|set_vec) |=> ((latch_q & $past(set_vec)) == $past(set_vec)));

    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (ack_valid && !set_vec[ack_level]) |=> !latch_q[$past(ack_level)]);

    assert_user_write_dropped_R9: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !reg_super) |=> (mask_q == $past(mask_q)));

    assert_user_read_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && !reg_super) |-> (reg_rdata == '0));

endmodule

bind prio_event_ctrl prio_event_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_super (reg_super),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .ack_valid (ack_valid),
    .ack_level (ack_level),
    .set_vec   (set_vec),
    .latch_q   (latch_q),
    .mask_q    (mask_q),
    .req_valid (req_valid),
    .req_level (req_level)
);

// File: tb/sim_prio_event_ctrl.sv
`timescale 1ns/1ps
module sim_prio_event_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] src_irq = '0;
    logic        ack_valid = 1'b0;
    logic [3:0]  ack_level = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic        reg_super = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_valid;
    logic [3:0]  req_level;

    always #10 clk = ~clk;

    prio_event_ctrl u0 (
        .clk(clk), .rst(rst), .src_irq(src_irq),
        .ack_valid(ack_valid), .ack_level(ack_level),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_super(reg_super),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .req_valid(req_valid), .req_level(req_level)
    );

    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 0;
    string       cur_req = "R1";
    int          amap [64];
    logic [15:0] m_latch;
    logic [15:0] m_mask;

    function automatic int spec_default(int s);
        if (s >= 8  && s <= 19) return 1;
        if (s >= 20 && s <= 31) return 2;
        if (s >= 32 && s <= 43) return 3;
        if (s >= 44 && s <= 49) return 4;
        if (s == 50 || s == 51) return 5;
        if (s == 52) return 6;
        return 0;
    endfunction

    function automatic logic [31:0] model_read();
        logic [31:0] v = '0;
        if (!(reg_rd && reg_super)) return '0;
        if (reg_addr < 8) begin
            for (int f = 0; f < 8; f++)
                v[f*4 +: 4] = 4'(amap[reg_addr*8 + f]);
        end else if (reg_addr == 8) v = {16'h0, m_latch};
        else if (reg_addr == 9) v = {16'h0, m_mask};
        return v;
    endfunction

    function automatic logic [4:0] model_req();
        for (int i = 0; i < 16; i++)
            if (m_latch[i] && m_mask[i]) return {1'b1, 4'(i)};
        return 5'h0;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step();
        logic [15:0] setv = '0;
        logic [15:0] clr  = '0;
        for (int s = 0; s < 64; s++)
            if (src_irq[s] && amap[s] <= 6) setv[amap[s] + 7] = 1'b1;
        if (ack_valid) clr[ack_level] = 1'b1;
        if (reg_wr && reg_super && reg_addr == 8) clr = clr | (reg_wdata[15:0] & ~m_mask);
        if (reg_wr && reg_super && reg_addr == 9) m_mask = reg_wdata[15:0];
        if (reg_wr && reg_super && reg_addr < 8)
            for (int f = 0; f < 8; f++) amap[reg_addr*8 + f] = int'(reg_wdata[f*4 +: 4]);
        m_latch = (m_latch & ~clr) | setv;
    endtask

    task automatic cyc();
        #1;
        if (reg_rd) chk(cur_req, reg_rdata, model_read());
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk(cur_req, {27'h0, req_valid, req_level}, {27'h0, model_req()});
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d, logic sup);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_super = sup;
        cyc();
        reg_wr = 1'b0; reg_super = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, logic sup);
        reg_rd = 1'b1; reg_addr = a; reg_super = sup;
        cyc();
        reg_rd = 1'b0; reg_super = 1'b0;
    endtask

    task automatic pulse(int s);
        src_irq[s] = 1'b1; cyc(); src_irq[s] = 1'b0;
    endtask

    task automatic ack(int l);
        ack_valid = 1'b1; ack_level = 4'(l); cyc(); ack_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < 64; s++) amap[s] = spec_default(s);
        m_latch = '0; m_mask = '0;
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        chk("R1", {31'h0, req_valid}, 32'h0);
        rst = 1'b0;
        cur_req = "R1";
        rd(4'd8, 1'b1);
        rd(4'd9, 1'b1);
        cur_req = "R2";
        for (int a = 0; a < 8; a++) rd(4'(a), 1'b1);

        cur_req = "R4";
        wr(4'd9, 32'h0000_FFFF, 1'b1);
        pulse(0);
        idle(2);
        chk("R4", {27'h0, req_valid, req_level}, {27'h0, 1'b1, 4'd7});
        ack(7);

        cur_req = "R6";
        src_irq[52] = 1'b1; src_irq[32] = 1'b1; src_irq[8] = 1'b1;
        cyc();
        src_irq = '0;
        chk("R6", {28'h0, req_level}, 32'd8);
        ack(8);
        chk("R6", {28'h0, req_level}, 32'd10);
        ack(10);
        ack(13);

        cur_req = "R5";
        wr(4'd9, 32'h0000_2000, 1'b1);
        src_irq[20] = 1'b1; src_irq[52] = 1'b1;
        cyc();
        src_irq = '0;
        chk("R5", {28'h0, req_level}, 32'd13);
        wr(4'd9, 32'h0000_FFFF, 1'b1);
        chk("R5", {28'h0, req_level}, 32'd9);
        ack(9); ack(13);

        cur_req = "R7";
        src_irq[44] = 1'b1;
        cyc();
        ack(11);
        chk("R7", {27'h0, req_valid, req_level}, {27'h0, 1'b1, 4'd11});
        src_irq[44] = 1'b0;
        ack(11);
        chk("R7", {31'h0, req_valid}, 32'h0);

        cur_req = "R3";
        wr(4'd0, 32'h0000_0096, 1'b1);
        rd(4'd0, 1'b1);
        pulse(0);
        chk("R3", {28'h0, req_level}, 32'd13);
        ack(13);
        pulse(1);
        chk("R3", {31'h0, req_valid}, 32'h0);
        rd(4'd8, 1'b1);

        cur_req = "R8";
        pulse(32);
        wr(4'd8, 32'h0000_0400, 1'b1);
        chk("R8", {28'h0, req_level}, 32'd10);
        wr(4'd9, 32'h0000_FBFF, 1'b1);
        rd(4'd8, 1'b1);
        wr(4'd8, 32'h0000_0400, 1'b1);
        rd(4'd8, 1'b1);
        wr(4'd9, 32'h0000_FFFF, 1'b1);

        cur_req = "R9";
        wr(4'd9, 32'h0, 1'b0);
        rd(4'd9, 1'b1);
        pulse(20);
        wr(4'd9, 32'h0000_FDFF, 1'b1);
        wr(4'd8, 32'h0000_0200, 1'b0);
        rd(4'd8, 1'b1);
        wr(4'd1, 32'hFFFF_FFFF, 1'b0);
        rd(4'd1, 1'b1);
        wr(4'd8, 32'h0000_0200, 1'b1);
        wr(4'd9, 32'h0000_FFFF, 1'b1);

        cur_req = "R10";
        pulse(52);
        rd(4'd8, 1'b0);
        rd(4'd9, 1'b0);
        rd(4'd12, 1'b1);
        rd(4'd15, 1'b1);
        ack(13);

        cur_req = "R6";
        for (int i = 0; i < 3000; i++) begin
            logic [4:0] er;
            src_irq = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom}
                    & {$urandom, $urandom} & {$urandom, $urandom};
            er = model_req();
            ack_valid = ($urandom % 2) == 0;
            ack_level = (($urandom % 4) == 0) ? 4'($urandom) : er[3:0];
            reg_wr = ($urandom % 8) == 0;
            reg_rd = ($urandom % 6) == 0;
            reg_super = ($urandom % 3) != 0;
            reg_addr = 4'(($urandom % 3 == 0) ? ($urandom % 8) : (8 + $urandom % 4));
            reg_wdata = $urandom;
            cyc();
        end
        src_irq = '0; ack_valid = 0; reg_wr = 0; reg_rd = 0; reg_super = 0;
        idle(2);

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule